// File: doc/BRIEF.md
# Completion Flag Barrier Synchronizer

The block gathers a set of one-shot completion flags in a source clock domain and tells an asynchronous destination domain when every flag of a round is set. Each flag is set by a single-cycle strobe and stays set. The wide AND of the flags is registered in the source domain, so only a flop output ever drives the crossing. A two-flop synchronizer carries that registered aggregate into the destination domain.

A destination-side filter accepts the completion only after a programmable number of consecutive high samples. It then raises a held request level, which is also the block's all-done output. The source domain synchronizes that level and turns its rising edge into a one-cycle clear pulse that drops every flag at once. The aggregate therefore falls exactly once. The destination releases the request only after it sees the synchronized aggregate low again, which re-arms it for the next round.

Top module: `flag_barrier_sync`

## Requirements
- R1: A strobe on `done_set_i[i]` sets flag i at the next source edge, and the flag stays set until the clear pulse. Repeating a strobe on an already set flag has no effect.
- R2: `all_done_o` never rises while any of the NUM_FLAGS (default 24) flags is clear, and it rises once all of them have been set in the current round.
- R3: Only a source-domain register drives the crossing. `all_done_o` is still low 3 destination clocks after the completing strobe has been removed.
- R4: `all_done_o` rises only after the synchronized aggregate has been sampled high on CONFIRM_SAMPLES consecutive destination clocks (default 2).
- R5: `clr_ack_o` is high for exactly one source clock per round.
- R6: The source edge that samples `clr_ack_o` high clears all flags together.
- R7: Each completed round produces exactly one clear pulse. The destination ignores completion until it has seen the synchronized aggregate low.
- R8: After the clear, `all_done_o` falls exactly once and stays low until every flag has been set again.
- R9: A strobe presented while `clr_ack_o` is high is discarded, and its producer must strobe again in the next round.
- R10: The active-high synchronous resets clear the flags, the filter count and both handshake levels. After reset both outputs are low and earlier strobes are forgotten.
- R11: With CONFIRM_SAMPLES set to 3, `all_done_o` rises exactly one destination clock later than with 2, given the same stimulus and clocks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| src_clk_i | input | 1 | Source domain clock |
| src_rst_i | input | 1 | Source domain synchronous reset, active high |
| done_set_i | input | NUM_FLAGS | Per-flag completion strobes, source domain |
| dst_clk_i | input | 1 | Destination domain clock |
| dst_rst_i | input | 1 | Destination domain synchronous reset, active high |
| all_done_o | output | 1 | Confirmed round completion, destination domain |
| clr_ack_o | output | 1 | One-cycle clear pulse applied to all flags, source domain |

## Verification
The properties assume that the request level stays low long enough for the source synchronizer to sample it, so the destination clock must not be so fast that a whole re-arm fits between two source edges. They also assume that strobes are synchronous to the source clock. The stimulus drives strobes for one source cycle on the falling edge and runs the destination clock only moderately faster than the source clock. It starts the completing strobes of a new round only after the previous round's all-done has fallen. The one deliberate overlap of a strobe with the clear pulse is placed exactly on the visible acknowledge cycle.

// File: rtl/fbs_pkg.sv
package fbs_pkg;

    typedef enum logic [0:0] {
        DST_WATCH = 1'b0,
        DST_HELD  = 1'b1
    } dst_state_e;

endpackage

// File: rtl/fbs_sync.sv
module fbs_sync #(
    parameter int STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic d_i,
    output logic q_o
);

    logic [STAGES-1:0] sr_d;
    logic [STAGES-1:0] sr_q;

    always_comb begin
        sr_d = {sr_q[STAGES-2:0], d_i};
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            sr_q <= '0;
        end else begin
            sr_q <= sr_d;
        end
    end

    assign q_o = sr_q[STAGES-1];

endmodule

// File: rtl/fbs_src_side.sv
module fbs_src_side #(
    parameter int NUM_FLAGS   = 24,
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk_i,
    input  logic                 rst_i,
    input  logic [NUM_FLAGS-1:0] set_i,
    input  logic                 req_async_i,
    output logic                 agg_o,
    output logic                 clr_o,
    output logic [NUM_FLAGS-1:0] flags_o
);

    typedef struct packed {
        logic [NUM_FLAGS-1:0] flags;
        logic                 agg;
        logic                 req_seen;
        logic                 pulse;
    } src_regs_t;

    src_regs_t            st_d;
    src_regs_t            st_q;
    logic                 req_s;
    logic [NUM_FLAGS-1:0] flag_nxt;

    fbs_sync #(.STAGES(SYNC_STAGES)) u_req_sync (
        .clk_i (clk_i),
        .rst_i (rst_i),
        .d_i   (req_async_i),
        .q_o   (req_s)
    );

    // Clear has priority over a strobe in the same cycle.
    for (genvar g = 0; g < NUM_FLAGS; g++) begin : g_flag
        assign flag_nxt[g] = st_q.pulse ? 1'b0 : (st_q.flags[g] | set_i[g]);
    end

    always_comb begin
        st_d          = st_q;
        st_d.flags    = flag_nxt;
        st_d.agg      = &st_q.flags;
        st_d.req_seen = req_s;
        st_d.pulse    = req_s & ~st_q.req_seen;
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign agg_o   = st_q.agg;
    assign clr_o   = st_q.pulse;
    assign flags_o = st_q.flags;

endmodule

// File: rtl/fbs_dst_side.sv
module fbs_dst_side
    import fbs_pkg::*;
#(
    parameter int CONFIRM_SAMPLES = 2,
    parameter int SYNC_STAGES     = 2
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic agg_async_i,
    output logic done_o,
    output logic agg_seen_o
);

    localparam int CNT_W = (CONFIRM_SAMPLES > 1) ? $clog2(CONFIRM_SAMPLES) : 1;
    localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(CONFIRM_SAMPLES - 1);

    typedef struct packed {
        dst_state_e       state;
        logic [CNT_W-1:0] cnt;
    } dst_regs_t;

    dst_regs_t r_d;
    dst_regs_t r_q;
    logic      agg_s;

    fbs_sync #(.STAGES(SYNC_STAGES)) u_agg_sync (
        .clk_i (clk_i),
        .rst_i (rst_i),
        .d_i   (agg_async_i),
        .q_o   (agg_s)
    );

    always_comb begin
        r_d = r_q;
        unique case (r_q.state)
            DST_WATCH: begin
                if (agg_s) begin
                    if (r_q.cnt == LAST_CNT) begin
                        r_d.state = DST_HELD;
                        r_d.cnt   = '0;
                    end else begin
                        r_d.cnt = r_q.cnt + CNT_W'(1);
                    end
                end else begin
                    r_d.cnt = '0;
                end
            end
            DST_HELD: begin
                if (!agg_s) begin
                    r_d.state = DST_WATCH;
                end
            end
            default: r_d.state = DST_WATCH;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            r_q <= '{state: DST_WATCH, cnt: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign done_o     = (r_q.state == DST_HELD);
    assign agg_seen_o = agg_s;

endmodule

// File: rtl/flag_barrier_sync.sv
module flag_barrier_sync #(
    parameter int NUM_FLAGS       = 24,
    parameter int CONFIRM_SAMPLES = 2,
    parameter int SYNC_STAGES     = 2
) (
    input  logic                 src_clk_i,
    input  logic                 src_rst_i,
    input  logic [NUM_FLAGS-1:0] done_set_i,
    input  logic                 dst_clk_i,
    input  logic                 dst_rst_i,
    output logic                 all_done_o,
    output logic                 clr_ack_o
);

    logic                 src_agg;
    logic                 src_clr;
    logic [NUM_FLAGS-1:0] src_flags;
    logic                 dst_done;
    logic                 dst_agg_seen;

    fbs_src_side #(
        .NUM_FLAGS   (NUM_FLAGS),
        .SYNC_STAGES (SYNC_STAGES)
    ) u_src (
        .clk_i       (src_clk_i),
        .rst_i       (src_rst_i),
        .set_i       (done_set_i),
        .req_async_i (dst_done),
        .agg_o       (src_agg),
        .clr_o       (src_clr),
        .flags_o     (src_flags)
    );

    fbs_dst_side #(
        .CONFIRM_SAMPLES (CONFIRM_SAMPLES),
        .SYNC_STAGES     (SYNC_STAGES)
    ) u_dst (
        .clk_i       (dst_clk_i),
        .rst_i       (dst_rst_i),
        .agg_async_i (src_agg),
        .done_o      (dst_done),
        .agg_seen_o  (dst_agg_seen)
    );

    assign all_done_o = dst_done;
    assign clr_ack_o  = src_clr;

endmodule

// File: rtl/fbs_checker.sv
module fbs_checker #(
    parameter int NUM_FLAGS       = 24,
    parameter int CONFIRM_SAMPLES = 2
) (
    input logic                 src_clk,
    input logic                 src_rst,
    input logic                 dst_clk,
    input logic                 dst_rst,
    input logic [NUM_FLAGS-1:0] flags,
    input logic [NUM_FLAGS-1:0] set,
    input logic                 agg,
    input logic                 clr_ack,
    input logic                 agg_seen,
    input logic                 all_done
);

    logic [3:0] run_q;
    logic       since_clr_q;

    always_ff @(posedge dst_clk) begin
        if (dst_rst || !agg_seen) begin
            run_q <= '0;
        end else if (run_q != 4'hF) begin
            run_q <= run_q + 4'd1;
        end
    end

    always_ff @(posedge src_clk) begin
        if (src_rst) begin
            since_clr_q <= 1'b0;
        end else if (clr_ack) begin
            since_clr_q <= 1'b1;
        end else if (!agg) begin
            since_clr_q <= 1'b0;
        end
    end

    AST_FLAG_STICKY: assert property (@(posedge src_clk) disable iff (src_rst)
        !clr_ack |=> ((flags & $past(flags)) == $past(flags))) else $error("flag dropped"); // R1

    AST_AGG_NEEDS_ALL: assert property (@(posedge src_clk) disable iff (src_rst)
        $rose(agg) |-> $past(&flags)) else $error("aggregate rose early"); // R3

    AST_CONFIRM_RUN: assert property (@(posedge dst_clk) disable iff (dst_rst)
        $rose(all_done) |-> (run_q >= 4'(CONFIRM_SAMPLES))) else $error("done without confirm"); // R4

    AST_CLR_ONE_CYCLE: assert property (@(posedge src_clk) disable iff (src_rst)
        clr_ack |=> !clr_ack) else $error("clear wider than one cycle"); // R5

    AST_CLR_DROPS_ALL: assert property (@(posedge src_clk) disable iff (src_rst)
        clr_ack |=> (flags == '0)) else $error("flags survived clear"); // R6

    AST_ONE_CLEAR_PER_ROUND: assert property (@(posedge src_clk) disable iff (src_rst)
        clr_ack |-> !since_clr_q) else $error("second clear in one round"); // R7

    AST_DONE_RELEASE: assert property (@(posedge dst_clk) disable iff (dst_rst)
        (all_done && !agg_seen) |=> !all_done) else $error("done held after aggregate low"); // R8

    AST_STROBE_LOSES: assert property (@(posedge src_clk) disable iff (src_rst)
        (clr_ack && (set != '0)) |=> (flags == '0)) else $error("strobe beat clear"); // R9

endmodule

bind flag_barrier_sync fbs_checker #(
    .NUM_FLAGS       (NUM_FLAGS),
    .CONFIRM_SAMPLES (CONFIRM_SAMPLES)
) u_chk (
    .src_clk  (src_clk_i),
    .src_rst  (src_rst_i),
    .dst_clk  (dst_clk_i),
    .dst_rst  (dst_rst_i),
    .flags    (src_flags),
    .set      (done_set_i),
    .agg      (src_agg),
    .clr_ack  (src_clr),
    .agg_seen (dst_agg_seen),
    .all_done (dst_done)
);

// File: tb/sim_flag_barrier_sync.sv
module sim_flag_barrier_sync;

    localparam int NF = 24;

    logic          src_clk = 1'b0;
    logic          dst_clk = 1'b0;
    logic          src_rst = 1'b1;
    logic          dst_rst = 1'b1;
    logic [NF-1:0] set_v   = '0;
    logic          done0, ack0, done1, ack1;

    always #10 src_clk = ~src_clk;
    always #4  dst_clk = ~dst_clk;

    flag_barrier_sync #(.NUM_FLAGS(NF), .CONFIRM_SAMPLES(2)) u0 (
        .src_clk_i (src_clk), .src_rst_i (src_rst), .done_set_i (set_v),
        .dst_clk_i (dst_clk), .dst_rst_i (dst_rst),
        .all_done_o (done0), .clr_ack_o (ack0)
    );

    flag_barrier_sync #(.NUM_FLAGS(NF), .CONFIRM_SAMPLES(3)) u1 (
        .src_clk_i (src_clk), .src_rst_i (src_rst), .done_set_i (set_v),
        .dst_clk_i (dst_clk), .dst_rst_i (dst_rst),
        .all_done_o (done1), .clr_ack_o (ack1)
    );

    int n_chk = 0;
    int n_fail = 0;

    // Monitors on u0 (and u1 rise time)
    int   ack_run = 0, ack_pulses = 0, ack_wmax = 0;
    int   dcyc = 0, rises0 = 0, falls0 = 0, rise0_at = 0, rise1_at = 0;
    logic pd0 = 1'b0, pd1 = 1'b0;

    always @(negedge src_clk) begin
        if (ack0 === 1'b1) begin
            ack_run++;
        end else begin
            if (ack_run > 0) begin
                ack_pulses++;
                if (ack_run > ack_wmax) ack_wmax = ack_run;
            end
            ack_run = 0;
        end
    end

    always @(negedge dst_clk) begin
        dcyc++;
        if (done0 === 1'b1 && !pd0) begin rises0++; rise0_at = dcyc; end
        if (done0 === 1'b0 && pd0)  falls0++;
        if (done1 === 1'b1 && !pd1) rise1_at = dcyc;
        pd0 = (done0 === 1'b1);
        pd1 = (done1 === 1'b1);
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic clear_mon();
        @(posedge src_clk);
        ack_pulses = 0; ack_wmax = 0; rises0 = 0; falls0 = 0;
        rise0_at = 0; rise1_at = 0;
    endtask

    task automatic strobe(input logic [NF-1:0] m);
        @(negedge src_clk);
        set_v = m;
        @(negedge src_clk);
        set_v = '0;
    endtask

    task automatic wait_done(input logic want, output bit seen);
        seen = 1'b0;
        for (int k = 0; k < 300; k++) begin
            @(negedge dst_clk);
            if (done0 === want) begin
                seen = 1'b1;
                break;
            end
        end
    endtask

    // {expected done, strobe mask}
    localparam logic [NF:0] VEC [8] = '{
        25'h0_000001, 25'h0_0000F0, 25'h0_000001, 25'h0_FFFF00,
        25'h1_00000E, 25'h0_800000, 25'h1_7FFFFF, 25'h1_FFFFFF
    };

    initial begin
        #1_000_000;
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        bit seen;
        repeat (4) @(negedge src_clk);
        check(done0 === 1'b0, "R10 reset done", done0, 0);
        check(ack0 === 1'b0, "R10 reset ack", ack0, 0);
        src_rst = 1'b0;
        dst_rst = 1'b0;
        repeat (4) @(negedge src_clk);

        for (int i = 0; i < 8; i++) begin
            logic          exp_done = VEC[i][NF];
            logic [NF-1:0] mask     = VEC[i][NF-1:0];
            clear_mon();
            strobe(mask);
            if (exp_done) begin
                repeat (3) @(negedge dst_clk);
                check(done0 === 1'b0, "R3/R4 early done", done0, 0);
                wait_done(1'b1, seen);
                check(seen, "R1/R2 completion", seen, 1);
                repeat (3) @(negedge dst_clk);
                check(rise1_at - rise0_at == 1, "R11 lag", rise1_at - rise0_at, 1);
                wait_done(1'b0, seen);
                check(seen, "R8 release", seen, 1);
                repeat (12) @(negedge src_clk);
                check(ack_pulses == 1, "R7 pulses", ack_pulses, 1);
                check(ack_wmax == 1, "R5 width", ack_wmax, 1);
                check(rises0 == 1 && falls0 == 1, "R8 single fall", falls0 * 10 + rises0, 11);
            end else begin
                repeat (20) @(negedge src_clk);
                check(done0 === 1'b0, "R1/R2/R6 partial", done0, 0);
                check(rises0 == 0, "R2/R8 no rise", rises0, 0);
            end
        end

        // Strobe collides with the clear pulse
        clear_mon();
        strobe('1);
        seen = 1'b0;
        for (int k = 0; k < 400; k++) begin
            @(negedge src_clk);
            if (ack0 === 1'b1) begin seen = 1'b1; break; end
        end
        check(seen, "R5 ack seen", seen, 1);
        set_v = 24'h000080;
        @(negedge src_clk);
        set_v = '0;
        wait_done(1'b0, seen);
        repeat (10) @(negedge src_clk);
        strobe(24'hFFFF7F);
        repeat (40) @(negedge src_clk);
        check(done0 === 1'b0, "R9 lost strobe", done0, 0);
        strobe(24'h000080);
        wait_done(1'b1, seen);
        check(seen, "R9 re-strobe", seen, 1);
        wait_done(1'b0, seen);
        repeat (10) @(negedge src_clk);

        // Reset mid-round
        strobe(24'h00FFFF);
        repeat (5) @(negedge src_clk);
        src_rst = 1'b1;
        dst_rst = 1'b1;
        repeat (3) @(negedge src_clk);
        check(done0 === 1'b0, "R10 done in reset", done0, 0);
        check(ack0 === 1'b0, "R10 ack in reset", ack0, 0);
        src_rst = 1'b0;
        dst_rst = 1'b0;
        repeat (4) @(negedge src_clk);
        strobe(24'hFF0000);
        repeat (40) @(negedge src_clk);
        check(done0 === 1'b0, "R10 flags forgotten", done0, 0);
        strobe(24'h00FFFF);
        wait_done(1'b1, seen);
        check(seen, "R10 round after reset", seen, 1);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule